// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host bus and the array back end of a NOR-style flash device. It watches every bus write, which is a clock cycle with chip enable and write enable both low, and tracks the multi-cycle unlock sequences. From these it enters an identification mode or a fast two-write programming mode, or it issues program and erase jobs. A job is handed to the back end as a held request carrying kind, address and data. It stays active until the back end returns a one-cycle done pulse.

The block also handles the device reset pin. While that pin is low, a running job is cancelled and all writes are ignored. After the pin is released, the data outputs stay disabled for a recovery period. That period is longer when a job was running at the moment of reset. An accelerated-program input forces the fast programming mode and lifts sector protection for as long as it is held. The block gates the data output enable, selects between array data and the identification register, and reports its mode and a busy flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: The writes 0xAA at word 0x555, 0x55 at 0x2AA and 0xA0 at 0x555 arm a program. The next write starts a job with jobKind 0 (program), jobAddr and jobData taken from that write. After that write, mode reads 4 (job) and busy and jobReq are 1.
- R2: The writes 0xAA/0x555, 0x55/0x2AA, 0x20/0x555 enter fast mode (mode 3). In fast mode, a write of 0xA0 at any address followed by one data write starts a program job. When the job completes, the block returns to mode 3.
- R3: In fast mode, 0x90 followed by 0x00 returns to read mode (mode 0). Any other second write after 0x90 keeps mode 3, and so does a write of 0xF0.
- R4: The writes 0xAA/0x555, 0x55/0x2AA, 0x90/0x555 enter identification mode (mode 2) with readSel 1. In this mode idData carries MFR_CODE at even addresses and DEV_CODE at odd addresses in bits 7:0, with bits 15:8 zero. Any write leaves to mode 0.
- R5: The erase prefix is 0xAA/0x555, 0x55/0x2AA, 0x80/0x555, 0xAA/0x555, 0x55/0x2AA. After the prefix, 0x30 at a sector address starts jobKind 1 (sector erase), and 0x10 at 0x555 starts jobKind 2 (chip erase). jobBank is 1 when jobAddr is at or above BOOT_BANK_WORDS and 0 otherwise.
- R6: Any write that breaks a normal unlock or erase sequence, including 0xF0, returns the block to mode 0. Mode 1 marks a partial sequence.
- R7: While a job runs, all writes are ignored, and raising ceN does not stop the job. jobReq stays high until jobDone is sampled. The block then returns to mode 0, or to mode 3 if the job was started from fast mode.
- R8: While fastProg is 1 and the device is ready, the block enters mode 3 on the next clock and protOverride is 1. The 0x90, 0x00 exit is ignored while fastProg is held. When fastProg falls, the block returns to mode 0.
- R9: While hwResetN is low, jobReq and busy go to 0, mode goes to 0, outEn is 0 and writes have no effect.
- R10: After hwResetN rises, outEn stays 0 and writes are ignored for LONG_WAIT clocks if a job was running when reset was asserted, and for SHORT_WAIT clocks otherwise.
- R11: outEn is 0 whenever oeN or ceN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| hwResetN | input | 1 | Device reset pin, active low, sampled on the clock |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| fastProg | input | 1 | Accelerated-program request |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| jobDone | input | 1 | Back end finished the current job |
| mode | output | 3 | 0 read, 1 sequence, 2 identification, 3 fast, 4 job |
| readSel | output | 1 | 1 selects the identification register |
| idData | output | DATA_W | Identification register read value |
| outEn | output | 1 | Data output drive enable |
| busy | output | 1 | Job running |
| protOverride | output | 1 | Sector protection lifted |
| jobReq | output | 1 | Job request to the back end |
| jobKind | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| jobAddr | output | ADDR_W | Job address |
| jobData | output | DATA_W | Program data |
| jobBank | output | 1 | Bank of jobAddr |

## Verification
The hardest case to reach is a reset that lands while a job is in flight, because the long recovery window only opens from that state. The stimulus starts a program job and leaves jobDone low. It then drops hwResetN, writes during the reset, and counts clocks from the release to the first cycle with outEn high. A second reset from idle measures the short window, and a write placed inside that window shows that the window also blocks commands.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int ADDR_UNLOCK_A = 'h555;
  localparam int ADDR_UNLOCK_B = 'h2AA;

  typedef enum logic [2:0] {
    MD_READ = 3'd0,
    MD_SEQ  = 3'd1,
    MD_ID   = 3'd2,
    MD_FAST = 3'd3,
    MD_JOB  = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    JK_PROG  = 2'd0,
    JK_SECT  = 2'd1,
    JK_CHIP  = 2'd2
  } jobKind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PROG_WAIT, S_AUTO,
    S_E1, S_E2, S_E3,
    S_BYP, S_BYP_PROG, S_BYP_EXIT, S_BUSY
  } seqState_e;

  typedef struct packed {
    logic     launch;
    jobKind_e kind;
    logic     idMode;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwResetN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              fastProg,
  input  logic              recReady,
  input  logic              jobDone,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmdByte,
  output ctlStrobe_t        strobes,
  output mode_e             mode,
  output logic              busy
);

  seqState_e state, nxt;
  logic accelQ, retByp;
  logic wrHit, atA, atB, inByp, accelFall;

  assign wrHit     = !ceN && !weN;
  assign atA       = addr == ADDR_W'(ADDR_UNLOCK_A);
  assign atB       = addr == ADDR_W'(ADDR_UNLOCK_B);
  assign inByp     = (state == S_BYP) || (state == S_BYP_PROG) || (state == S_BYP_EXIT);
  assign accelFall = accelQ && !fastProg;
  assign busy      = state == S_BUSY;

  always_comb begin
    nxt = state;
    strobes.launch = 1'b0;
    strobes.kind   = JK_PROG;
    strobes.idMode = state == S_AUTO;
    if (state == S_BUSY) begin
      if (jobDone) nxt = (retByp || fastProg) ? S_BYP : S_IDLE;
    end else if (!recReady) begin
      nxt = state;
    end else if (fastProg && !inByp) begin
      nxt = S_BYP;
    end else if (accelFall && inByp) begin
      nxt = S_IDLE;
    end else if (wrHit) begin
      case (state)
        S_IDLE:      nxt = (atA && cmdByte == 8'hAA) ? S_U1 : S_IDLE;
        S_U1:        nxt = (atB && cmdByte == 8'h55) ? S_U2 : S_IDLE;
        S_U2: begin
          nxt = S_IDLE;
          if (atA) begin
            case (cmdByte)
              8'hA0:   nxt = S_PROG_WAIT;
              8'h90:   nxt = S_AUTO;
              8'h20:   nxt = S_BYP;
              8'h80:   nxt = S_E1;
              default: nxt = S_IDLE;
            endcase
          end
        end
        S_PROG_WAIT, S_BYP_PROG: begin
          strobes.launch = 1'b1;
          strobes.kind   = JK_PROG;
          nxt            = S_BUSY;
        end
        S_AUTO:      nxt = S_IDLE;
        S_E1:        nxt = (atA && cmdByte == 8'hAA) ? S_E2 : S_IDLE;
        S_E2:        nxt = (atB && cmdByte == 8'h55) ? S_E3 : S_IDLE;
        S_E3: begin
          nxt = S_IDLE;
          if (cmdByte == 8'h30) begin
            strobes.launch = 1'b1;
            strobes.kind   = JK_SECT;
            nxt            = S_BUSY;
          end else if (cmdByte == 8'h10 && atA) begin
            strobes.launch = 1'b1;
            strobes.kind   = JK_CHIP;
            nxt            = S_BUSY;
          end
        end
        S_BYP: begin
          if (cmdByte == 8'hA0)      nxt = S_BYP_PROG;
          else if (cmdByte == 8'h90) nxt = S_BYP_EXIT;
          else                       nxt = S_BYP;
        end
        S_BYP_EXIT:  nxt = (cmdByte == 8'h00 && !fastProg) ? S_IDLE : S_BYP;
        default:     nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      accelQ <= 1'b0;
      retByp <= 1'b0;
    end else if (!hwResetN) begin
      state  <= S_IDLE;
      accelQ <= fastProg;
      retByp <= 1'b0;
    end else begin
      state  <= nxt;
      accelQ <= fastProg;
      if (strobes.launch) retByp <= inByp;
      else if (accelFall) retByp <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      S_IDLE:                      mode = MD_READ;
      S_AUTO:                      mode = MD_ID;
      S_BYP, S_BYP_PROG, S_BYP_EXIT: mode = MD_FAST;
      S_BUSY:                      mode = MD_JOB;
      default:                     mode = MD_SEQ;
    endcase
  end

  // R9: a held reset puts the sequencer back in read mode
  assert_reset_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hwResetN |=> state == S_IDLE);

  // R8: the accelerated input forces fast mode (or a job started from it)
  assert_accel_fast_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hwResetN && recReady && fastProg && state != S_BUSY) |=> (inByp || busy));

  // R7: a job only ends on done or reset
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hwResetN && busy && !jobDone) |=> busy);

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W          = 22,
  parameter int          DATA_W          = 16,
  parameter int          BOOT_BANK_WORDS = 32768,
  parameter int          SHORT_WAIT      = 6,
  parameter int          LONG_WAIT       = 24,
  parameter logic [7:0]  MFR_CODE        = 8'h01,
  parameter logic [7:0]  DEV_CODE        = 8'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwResetN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              fastProg,
  input  logic              jobDone,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  ctlStrobe_t        strobes,
  output logic              recReady,
  output logic              jobReq,
  output logic [1:0]        jobKind,
  output logic [ADDR_W-1:0] jobAddr,
  output logic [DATA_W-1:0] jobData,
  output logic              jobBank,
  output logic              outEn,
  output logic              readSel,
  output logic [DATA_W-1:0] idData,
  output logic              protOverride
);

  localparam int CNT_W = $clog2(LONG_WAIT + 1);

  logic [CNT_W-1:0] waitCnt;
  logic             longPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jobReq  <= 1'b0;
      jobKind <= 2'd0;
      jobAddr <= '0;
      jobData <= '0;
    end else if (!hwResetN) begin
      jobReq <= 1'b0;
    end else if (strobes.launch) begin
      jobReq  <= 1'b1;
      jobKind <= strobes.kind;
      jobAddr <= addr;
      jobData <= wdata;
    end else if (jobDone) begin
      jobReq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      longPend <= 1'b0;
    end else if (!hwResetN) begin
      longPend <= longPend || busy;
      waitCnt  <= (longPend || busy) ? CNT_W'(LONG_WAIT) : CNT_W'(SHORT_WAIT);
    end else begin
      longPend <= 1'b0;
      if (waitCnt != '0) waitCnt <= waitCnt - CNT_W'(1);
    end
  end

  assign recReady     = waitCnt == '0;
  assign outEn        = hwResetN && recReady && !ceN && !oeN;
  assign readSel      = strobes.idMode;
  assign protOverride = fastProg && hwResetN;
  assign jobBank      = jobAddr >= ADDR_W'(BOOT_BANK_WORDS);
  assign idData       = {{(DATA_W-8){1'b0}}, (addr[0] ? DEV_CODE : MFR_CODE)};

  // R1: the request seen by the back end tracks the sequencer busy state
  assert_job_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    busy == jobReq);

  // R10: a held reset always opens a recovery window
  assert_reset_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    !hwResetN |=> !recReady);

  // R7: a launched job stays requested until done or reset
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hwResetN && jobReq && !jobDone) |=> jobReq);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W          = 22,
  parameter int          DATA_W          = 16,
  parameter int          BOOT_BANK_WORDS = 32768,
  parameter int          SHORT_WAIT      = 6,
  parameter int          LONG_WAIT       = 24,
  parameter logic [7:0]  MFR_CODE        = 8'h01,
  parameter logic [7:0]  DEV_CODE        = 8'h7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwResetN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              fastProg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              jobDone,
  output logic [2:0]        mode,
  output logic              readSel,
  output logic [DATA_W-1:0] idData,
  output logic              outEn,
  output logic              busy,
  output logic              protOverride,
  output logic              jobReq,
  output logic [1:0]        jobKind,
  output logic [ADDR_W-1:0] jobAddr,
  output logic [DATA_W-1:0] jobData,
  output logic              jobBank
);

  ctlStrobe_t strobes;
  mode_e      modeInt;
  logic       recReady;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .ceN(ceN), .weN(weN),
    .fastProg(fastProg), .recReady(recReady), .jobDone(jobDone),
    .addr(addr), .cmdByte(wdata[7:0]), .strobes(strobes),
    .mode(modeInt), .busy(busy)
  );

  flash_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_BANK_WORDS(BOOT_BANK_WORDS),
    .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .ceN(ceN), .oeN(oeN),
    .fastProg(fastProg), .jobDone(jobDone), .busy(busy), .addr(addr),
    .wdata(wdata), .strobes(strobes), .recReady(recReady), .jobReq(jobReq),
    .jobKind(jobKind), .jobAddr(jobAddr), .jobData(jobData), .jobBank(jobBank),
    .outEn(outEn), .readSel(readSel), .idData(idData), .protOverride(protOverride)
  );

  assign mode = modeInt;

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/100ps
module flash_cmd_seq_tb_top;

  localparam int SHORT_W = 6;
  localparam int LONG_W  = 24;

  logic clk = 1'b0;
  logic rstN, hwResetN, ceN, weN, oeN, fastProg, jobDone;
  logic [21:0] addr;
  logic [15:0] wdata, idData, jobData;
  logic [2:0]  mode;
  logic [1:0]  jobKind;
  logic [21:0] jobAddr;
  logic readSel, outEn, busy, protOverride, jobReq, jobBank;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .ceN(ceN), .weN(weN),
    .oeN(oeN), .fastProg(fastProg), .addr(addr), .wdata(wdata),
    .jobDone(jobDone), .mode(mode), .readSel(readSel), .idData(idData),
    .outEn(outEn), .busy(busy), .protOverride(protOverride), .jobReq(jobReq),
    .jobKind(jobKind), .jobAddr(jobAddr), .jobData(jobData), .jobBank(jobBank)
  );

  typedef struct packed {
    logic [21:0] a;
    logic [15:0] d;
    logic [2:0]  m;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{22'h555, 16'h00AA, 3'd1}, '{22'h2AA, 16'h0055, 3'd1},
    '{22'h555, 16'h0090, 3'd2},   // R4 enter
    '{22'h000, 16'h00F0, 3'd0},   // R4 leave
    '{22'h555, 16'h00AA, 3'd1},
    '{22'h2AA, 16'h0012, 3'd0},   // R6 bad second cycle
    '{22'h555, 16'h00AA, 3'd1}, '{22'h2AA, 16'h0055, 3'd1},
    '{22'h555, 16'h00F0, 3'd0},   // R6 reset command
    '{22'h555, 16'h00AA, 3'd1}, '{22'h2AA, 16'h0055, 3'd1},
    '{22'h555, 16'h0020, 3'd3},   // R2 enter fast mode
    '{22'h000, 16'h00F0, 3'd3},   // R3 stays
    '{22'h000, 16'h0090, 3'd3},
    '{22'h000, 16'h0011, 3'd3},   // R3 bad exit
    '{22'h000, 16'h0090, 3'd3},
    '{22'h000, 16'h0000, 3'd0},   // R3 exit
    '{22'h555, 16'h00AA, 3'd1}, '{22'h2AA, 16'h0055, 3'd1},
    '{22'h555, 16'h0080, 3'd1}, '{22'h555, 16'h00AA, 3'd1},
    '{22'h2AA, 16'h0055, 3'd1},
    '{22'h123, 16'h00F0, 3'd0}    // R6 broken erase
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    addr = a; wdata = d; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
  endtask

  task automatic unlock(input logic [15:0] cmd);
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, cmd);
  endtask

  task automatic pulseDone();
    jobDone = 1'b1;
    @(negedge clk);
    jobDone = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; hwResetN = 0; ceN = 0; weN = 1; oeN = 0; fastProg = 0;
    jobDone = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R9 reset mode", mode, 0);
    chk("R9 reset jobReq", jobReq, 0);
    chk("R9 reset outEn", outEn, 0);

    // idle reset release: short window, writes ignored inside it
    hwResetN = 1;
    wr(22'h555, 16'h00AA);
    chk("R10 write in window ignored", mode, 0);
    repeat (SHORT_W - 2) @(negedge clk);
    chk("R10 short window closed", outEn, 0);
    @(negedge clk);
    chk("R10 short window open", outEn, 1);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].d);
      chk($sformatf("table vector %0d mode", i), mode, VECS[i].m);
    end

    // R4 identification reads
    unlock(16'h0090);
    chk("R4 readSel", readSel, 1);
    addr = 22'h000; #1;
    chk("R4 mfr code", idData, 16'h0001);
    addr = 22'h001; #1;
    chk("R4 dev code", idData, 16'h007E);
    wr(22'h000, 16'h00F0);
    chk("R4 back to read", readSel, 0);

    // R1 four-cycle program, R7 busy behaviour
    unlock(16'h00A0);
    chk("R1 armed", mode, 1);
    wr(22'h000ABC, 16'h1234);
    chk("R1 mode job", mode, 4);
    chk("R1 busy", busy, 1);
    chk("R1 kind", jobKind, 0);
    chk("R1 addr", jobAddr, 22'h000ABC);
    chk("R1 data", jobData, 16'h1234);
    chk("R5 bank low", jobBank, 0);
    wr(22'h555, 16'h00AA);
    chk("R7 write ignored", mode, 4);
    ceN = 1;
    repeat (3) @(negedge clk);
    chk("R7 job survives ceN", jobReq, 1);
    chk("R11 ceN gates outEn", outEn, 0);
    ceN = 0;
    pulseDone();
    chk("R7 done to read", mode, 0);
    chk("R7 req dropped", jobReq, 0);

    // R5 erases
    unlock(16'h0080);
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h200000, 16'h0030);
    chk("R5 sector kind", jobKind, 1);
    chk("R5 bank high", jobBank, 1);
    pulseDone();
    unlock(16'h0080);
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, 16'h0010);
    chk("R5 chip kind", jobKind, 2);
    pulseDone();

    // R2 two-write program in fast mode
    unlock(16'h0020);
    wr(22'h000, 16'h00A0);
    wr(22'h000040, 16'h5555);
    chk("R2 fast job", mode, 4);
    chk("R2 fast addr", jobAddr, 22'h000040);
    pulseDone();
    chk("R2 back to fast", mode, 3);
    wr(22'h000, 16'h0090);
    wr(22'h000, 16'h0000);
    chk("R3 exit", mode, 0);

    // R8 accelerated input
    fastProg = 1;
    @(negedge clk);
    chk("R8 forced fast", mode, 3);
    chk("R8 protection lifted", protOverride, 1);
    wr(22'h000, 16'h0090);
    wr(22'h000, 16'h0000);
    chk("R8 exit ignored", mode, 3);
    wr(22'h000, 16'h00A0);
    wr(22'h000100, 16'h7777);
    chk("R8 program addr", jobAddr, 22'h000100);
    pulseDone();
    chk("R8 still fast", mode, 3);
    fastProg = 0;
    @(negedge clk);
    chk("R8 released", mode, 0);
    chk("R8 protection back", protOverride, 0);

    // R11 output enable
    oeN = 1; #1;
    chk("R11 oeN gates outEn", outEn, 0);
    oeN = 0; #1;
    chk("R11 enabled", outEn, 1);

    // R9/R10 reset during a job
    unlock(16'h00A0);
    wr(22'h000200, 16'h0F0F);
    chk("R9 job running", busy, 1);
    hwResetN = 0;
    @(negedge clk);
    chk("R9 job aborted", jobReq, 0);
    chk("R9 busy cleared", busy, 0);
    chk("R9 outEn off", outEn, 0);
    wr(22'h555, 16'h00AA);
    chk("R9 write ignored", mode, 0);
    @(negedge clk);
    hwResetN = 1;
    repeat (LONG_W - 1) @(negedge clk);
    chk("R10 long window closed", outEn, 0);
    @(negedge clk);
    chk("R10 long window open", outEn, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule